// File: doc/BRIEF.md
# Crosspoint switch configuration controller

This block is the digital programming side of a matrix that connects each of eight outputs to one of eight inputs or to nothing. A 4-bit selection code is kept per output. Writes land in a staging (master) register. A second, active (slave) register holds the codes that are actually decoded into the switch state. Each output gets a 9-bit one-hot vector: one bit for each input, plus one bit that means "disconnected".

A strap picks the write path. In serial mode the master register is a 32-bit shift register. Its top bit leaves on a serial output, so several devices can be chained. In parallel mode an address and a 4-bit data word are written per strobe. Some data values are commands rather than codes. A second strap chooses how the latch input moves the staged codes into the active register. In edge mode the copy happens on the latch rising edge. In level mode the active register follows the staging register while the latch input is low. All pins are sampled on one system clock, and a write or latch "edge" is a low-to-high change seen between two clock samples.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: After reset every field of both registers holds 1000. Every output vector shows only its disconnect bit (bit 8), and the serial output is 1.
- R2: A write strobe rising edge has an effect only while ce_n is 0 and ce is 1. With any other enable combination the master register does not change.
- R3: In parallel mode a write with data 0000..1000 stores the data into output field `addr`, bits [4*addr+3:4*addr] of the master. Every other field is left unchanged.
- R4: In parallel mode the data values 1001, 1010, 1100, 1101 and 1110 change neither register.
- R5: In parallel mode data 1011 sets every field of both registers to 1000 on that write, whatever the latch input and latch strap are.
- R6: In parallel mode data 1111 copies the whole master register into the slave register on that write.
- R7: With latch_edge = 1 the slave register loads the master only on a rising edge of latch. A falling edge or a steady level leaves the slave unchanged.
- R8: With latch_edge = 0 the slave register follows the master, one clock behind, while latch is 0. While latch is 1 the slave holds.
- R9: In serial mode each accepted write shifts the master left by one bit, with data[0] entering bit 0. ser_out always carries master bit 31.
- R10: Output k's vector sel[9k+8:9k] has exactly one bit set. A slave code c in 0..7 sets bit c. Any code of 8 or more sets bit 8 only.
- R11: In serial mode, data values that are commands in parallel mode (1011, 1111) only shift the register and do not touch the slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, all pins sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_mode | input | 1 | Write path strap: 1 serial, 0 parallel |
| latch_edge | input | 1 | Latch strap: 1 edge, 0 transparent-low level |
| ce_n | input | 1 | Active-low chip enable |
| ce | input | 1 | Active-high chip enable |
| wr | input | 1 | Write strobe, acts on its rising edge |
| latch | input | 1 | Latch control input |
| addr | input | 3 | Output index for parallel writes |
| data | input | 4 | Parallel code or command; bit 0 is the serial input |
| ser_out | output | 1 | Master register bit 31, for chaining |
| sel | output | 72 | Nine-bit one-hot select per output, output k at [9k+8:9k] |

## Verification
A corrupted master field stays hidden until a copy into the slave brings it to `sel`, either by the next software latch or latch edge, or by the next cycle in transparent mode. The bench therefore follows every staged write with a latch and compares all 72 select bits. The bench also checks that `sel` is unchanged before the latch. Field 7's top bit reaches `ser_out` within one clock of a write, so shift-order faults show after one strobe. A decoder fault shows at once on the select vector of the affected output.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;
  localparam int CODE_W = 4;
  localparam int NIN    = 8;
  localparam int DEC_W  = NIN + 1;

  localparam logic [CODE_W-1:0] CODE_OFF  = 4'b1000;
  localparam logic [CODE_W-1:0] CMD_CLEAR = 4'b1011;
  localparam logic [CODE_W-1:0] CMD_LATCH = 4'b1111;

  // a code that may be stored into a field
  function automatic logic code_storable(input logic [CODE_W-1:0] c);
    return c <= CODE_OFF;
  endfunction

  // one-hot select: input index for codes below NIN, disconnect flag otherwise
  function automatic logic [DEC_W-1:0] code_decode(input logic [CODE_W-1:0] c);
    logic [DEC_W-1:0] v;
    v = '0;
    if (c < CODE_W'(NIN)) v[c] = 1'b1;
    else v[NIN] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/xpt_cfg_edge.sv
module xpt_cfg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/xpt_cfg_master.sv
module xpt_cfg_master
  import xpt_cfg_pkg::*;
#(
  parameter int NOUT = 8,
  localparam int REG_W  = NOUT * CODE_W,
  localparam int ADDR_W = (NOUT > 1) ? $clog2(NOUT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              ser_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] data,
  output logic [REG_W-1:0]  master,
  output logic              cmd_clear,
  output logic              cmd_swlatch
);
  localparam logic [REG_W-1:0] ALL_OFF = {NOUT{CODE_OFF}};

  logic par_evt;
  logic addr_ok;

  assign par_evt     = wr_evt & ~ser_mode;
  assign addr_ok     = int'(addr) < NOUT;
  assign cmd_clear   = par_evt & (data == CMD_CLEAR);
  assign cmd_swlatch = par_evt & (data == CMD_LATCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master <= ALL_OFF;
    end else if (wr_evt && ser_mode) begin
      master <= {master[REG_W-2:0], data[0]};
    end else if (cmd_clear) begin
      master <= ALL_OFF;
    end else if (par_evt && code_storable(data) && addr_ok) begin
      master[int'(addr)*CODE_W +: CODE_W] <= data;
    end
  end
endmodule

// File: rtl/xpt_cfg_slave.sv
module xpt_cfg_slave
  import xpt_cfg_pkg::*;
#(
  parameter int NOUT = 8,
  localparam int REG_W = NOUT * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] master,
  input  logic             cmd_clear,
  input  logic             cmd_swlatch,
  input  logic             latch_edge,
  input  logic             latch,
  input  logic             latch_rise,
  output logic [REG_W-1:0] slave,
  output logic             slave_ld
);
  localparam logic [REG_W-1:0] ALL_OFF = {NOUT{CODE_OFF}};

  logic hw_ld;

  assign hw_ld    = latch_edge ? latch_rise : ~latch;
  assign slave_ld = hw_ld | cmd_swlatch;

  always_ff @(posedge clk) begin
    if (!rst_n) slave <= ALL_OFF;
    else if (cmd_clear) slave <= ALL_OFF;
    else if (slave_ld) slave <= master;
  end
endmodule

// File: rtl/xpt_cfg_dec.sv
module xpt_cfg_dec
  import xpt_cfg_pkg::*;
#(
  parameter int NOUT = 8,
  localparam int REG_W = NOUT * CODE_W,
  localparam int SEL_W = NOUT * DEC_W
) (
  input  logic [REG_W-1:0] slave,
  output logic [SEL_W-1:0] sel
);
  for (genvar k = 0; k < NOUT; k++) begin : g_out
    assign sel[k*DEC_W +: DEC_W] = code_decode(slave[k*CODE_W +: CODE_W]);
  end
endmodule

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl
  import xpt_cfg_pkg::*;
#(
  parameter int NOUT = 8,
  localparam int REG_W  = NOUT * CODE_W,
  localparam int SEL_W  = NOUT * DEC_W,
  localparam int ADDR_W = (NOUT > 1) ? $clog2(NOUT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_mode,
  input  logic              latch_edge,
  input  logic              ce_n,
  input  logic              ce,
  input  logic              wr,
  input  logic              latch,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] data,
  output logic              ser_out,
  output logic [SEL_W-1:0]  sel
);
  logic             wr_rise;
  logic             wr_evt;
  logic             latch_rise;
  logic             cmd_clear;
  logic             cmd_swlatch;
  logic             slave_ld;
  logic [REG_W-1:0] master;
  logic [REG_W-1:0] slave;

  xpt_cfg_edge u_wr_edge (
    .clk(clk), .rst_n(rst_n), .lvl(wr), .rise(wr_rise)
  );

  xpt_cfg_edge u_lat_edge (
    .clk(clk), .rst_n(rst_n), .lvl(latch), .rise(latch_rise)
  );

  assign wr_evt = wr_rise & ~ce_n & ce;

  xpt_cfg_master #(.NOUT(NOUT)) u_master (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .ser_mode(ser_mode),
    .addr(addr), .data(data), .master(master),
    .cmd_clear(cmd_clear), .cmd_swlatch(cmd_swlatch)
  );

  xpt_cfg_slave #(.NOUT(NOUT)) u_slave (
    .clk(clk), .rst_n(rst_n), .master(master), .cmd_clear(cmd_clear),
    .cmd_swlatch(cmd_swlatch), .latch_edge(latch_edge), .latch(latch),
    .latch_rise(latch_rise), .slave(slave), .slave_ld(slave_ld)
  );

  xpt_cfg_dec #(.NOUT(NOUT)) u_dec (
    .slave(slave), .sel(sel)
  );

  assign ser_out = master[REG_W-1];
endmodule

// File: rtl/xpt_cfg_chk.sv
module xpt_cfg_chk
  import xpt_cfg_pkg::*;
#(
  parameter int NOUT = 8,
  localparam int REG_W = NOUT * CODE_W,
  localparam int SEL_W = NOUT * DEC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_mode,
  input logic              latch_edge,
  input logic              ce_n,
  input logic              ce,
  input logic              latch,
  input logic [CODE_W-1:0] data,
  input logic              wr_evt,
  input logic [REG_W-1:0]  master,
  input logic [REG_W-1:0]  slave,
  input logic [SEL_W-1:0]  sel
);
  localparam logic [REG_W-1:0] ALL_OFF = {NOUT{CODE_OFF}};

  // R2
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || !ce) |=> $stable(master));

  // R9
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && ser_mode) |=> master == {$past(master[REG_W-2:0]), $past(data[0])});

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !ser_mode && data == CMD_CLEAR) |=> (master == ALL_OFF && slave == ALL_OFF));

  // R6
  swlatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !ser_mode && data == CMD_LATCH) |=> slave == $past(master));

  // R7
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_edge && !$rose(latch) && !wr_evt) |=> $stable(slave));

  // R8
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_edge && !latch && !wr_evt) |=> slave == $past(master));

  // R10
  for (genvar k = 0; k < NOUT; k++) begin : g_oh
    onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel[k*DEC_W +: DEC_W]) == 1);
  end
endmodule

bind xpt_cfg_ctrl xpt_cfg_chk #(.NOUT(NOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .latch_edge(latch_edge),
  .ce_n(ce_n), .ce(ce), .latch(latch), .data(data), .wr_evt(wr_evt),
  .master(master), .slave(slave), .sel(sel)
);

// File: tb/xpt_cfg_ctrl_bench.sv
module xpt_cfg_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_mode = 1'b0;
  logic        latch_edge = 1'b1;
  logic        ce_n = 1'b0;
  logic        ce = 1'b1;
  logic        wr = 1'b0;
  logic        latch = 1'b1;
  logic [2:0]  addr = '0;
  logic [3:0]  data = '0;
  logic        ser_out;
  logic [71:0] sel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] exp_m;
  logic [31:0] exp_s;

  always #4 clk = ~clk;

  xpt_cfg_ctrl u_xpt_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .latch_edge(latch_edge),
    .ce_n(ce_n), .ce(ce), .wr(wr), .latch(latch), .addr(addr), .data(data),
    .ser_out(ser_out), .sel(sel)
  );

  function automatic logic [71:0] model_sel(input logic [31:0] s);
    logic [71:0] v = '0;
    for (int k = 0; k < 8; k++) begin
      int c = int'(s[4*k +: 4]);
      v[9*k + ((c > 7) ? 8 : c)] = 1'b1;
    end
    return v;
  endfunction

  task automatic check_all(input string req);
    total++;
    if (sel !== model_sel(exp_s)) begin
      bad++;
      $display("FAIL %s sel actual=%h expected=%h", req, sel, model_sel(exp_s));
    end
    total++;
    if (ser_out !== exp_m[31]) begin
      bad++;
      $display("FAIL %s ser_out actual=%b expected=%b", req, ser_out, exp_m[31]);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one strobe plus model update; outputs settled at return
  task automatic do_write(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; data = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    @(negedge clk);
    if (!ce_n && ce) begin
      if (ser_mode) exp_m = {exp_m[30:0], d[0]};
      else if (d <= 4'd8) exp_m[4*a +: 4] = d;
      else if (d == 4'd11) begin exp_m = {8{4'h8}}; exp_s = exp_m; end
      else if (d == 4'd15) exp_s = exp_m;
    end
    if (!latch_edge && !latch) exp_s = exp_m;
  endtask

  task automatic pulse_latch(input string req);
    latch = 1'b0;
    idle(2);
    if (!latch_edge) exp_s = exp_m;
    check_all(req);
    latch = 1'b1;
    idle(2);
    if (latch_edge) exp_s = exp_m;
    check_all(req);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    exp_m = {8{4'h8}};
    exp_s = exp_m;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check_all("R1");

    // R3 / R6 / R7: every address with every storable code
    for (int a = 0; a < 8; a++) begin
      for (int c = 0; c <= 8; c++) begin
        do_write(3'(a), 4'(c));
        check_all("R7");
        do_write(3'(7 - a), 4'd15);
        check_all("R3");
      end
    end

    // R4: ignored codes
    do_write(3'd1, 4'd5);
    do_write(3'd0, 4'd15);
    for (int c = 9; c <= 14; c++) begin
      if (c != 11) begin
        do_write(3'(c - 8), 4'(c));
        do_write(3'd0, 4'd15);
        check_all("R4");
      end
    end

    // R2: write strobe gated by both enables
    ce_n = 1'b1;
    do_write(3'd1, 4'd2);
    ce_n = 1'b0; ce = 1'b0;
    do_write(3'd1, 4'd3);
    ce = 1'b1;
    do_write(3'd0, 4'd15);
    check_all("R2");

    // R7: hardware latch edge
    do_write(3'd2, 4'd6);
    check_all("R7");
    pulse_latch("R7");

    // R5: clear with latch held high
    do_write(3'd3, 4'd4);
    do_write(3'd0, 4'd11);
    check_all("R5");

    // R8: transparent level mode
    latch_edge = 1'b0;
    latch = 1'b0;
    idle(2);
    do_write(3'd4, 4'd6);
    check_all("R8");
    latch = 1'b1;
    idle(1);
    do_write(3'd4, 4'd2);
    check_all("R8");
    latch = 1'b0;
    idle(2);
    exp_s = exp_m;
    check_all("R8");
    do_write(3'd5, 4'd11);
    check_all("R5");

    // R9 / R11 / R10: serial shift of a pattern with codes above 8
    latch_edge = 1'b1;
    latch = 1'b1;
    idle(2);
    ser_mode = 1'b1;
    for (int i = 31; i >= 0; i--) begin
      logic [31:0] pat = 32'h9AF3_0725;
      logic b = pat[i];
      do_write(3'd0, b ? 4'b1111 : 4'b1010);
      check_all("R9");
    end
    do_write(3'd0, 4'b1011);
    check_all("R11");
    pulse_latch("R10");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule